// File: doc/BRIEF.md
# Character stream cursor formatter

This block sits between a producer of ASCII text and an engine that performs the actual bus accesses of a character display with 3 rows of 16 columns. Text arrives one byte at a time over a valid/ready handshake. The block keeps a cursor position, row and column, and turns each byte into one or more display writes. Every write is a byte with a register-select tag, RS = 1 for a data (glyph) write and RS = 0 for a command. Writes leave over a second valid/ready handshake toward the access engine.

Printable bytes become data writes. The cursor follows the display's own auto-increment, including the wrap from the end of one line to the start of the next. When the cursor has to jump, the block issues a set-address command. That happens for carriage return, for newline, and when the cursor falls off the last cell back to the top-left corner. Tab expands to a fixed run of spaces. Newline blanks the rest of the current line before moving down. A separate clear request wipes the display and homes the cursor.

The row count, column count and tab width are parameters. The defaults are 3, 16 and 4.

Top module: `txt_cursor_fmt`

## Requirements
- R1: Any input byte other than 0x09, 0x0A and 0x0D becomes exactly one output write with RS=1 carrying that byte, and the cursor column advances by one.
- R2: A data write made at column 16 of rows 1 or 2 moves the cursor to column 1 of the next row with no command, so the next byte is written there as data only.
- R3: A data write made at row 3, column 16 is followed by the command 0x80 (RS=0), and the cursor returns to row 1, column 1.
- R4: Byte 0x09 produces TAB_LEN (default 4) data writes of 0x20. Each one follows the same cursor rules as R1 to R3.
- R5: Byte 0x0D moves the cursor to column 1 of the current row and emits the command 0x80 | ((row-1)*16) with RS=0. Every command is either such a set-address (bit 7 set) or the clear command 0x01.
- R6: Byte 0x0A emits 0x20 data writes for every column from the cursor column through column 16. It then emits the set-address command for column 1 of the next row, where the row after 3 is 1. The address byte's low 7 bits never reach 48.
- R7: While outValid is high and outReady is low, outValid, outByte and outRs hold. Every write is delivered exactly once, in order.
- R8: inReady is high only when the block has no write of a previous byte left to produce. After a byte is accepted, inReady is low in the next cycle, and it stays low for as long as a tab or newline expansion is being stalled.
- R9: A clearReq pulse while idle emits the command 0x01 (RS=0) and homes the cursor to row 1, column 1. clearReq takes priority over inValid: inReady is low while clearReq is high.
- R10: While rstN is low, outValid is low and inReady is high, and the cursor is at row 1, column 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input text byte valid |
| inReady | output | 1 | Block accepts the input byte |
| inByte | input | 8 | ASCII input byte |
| clearReq | input | 1 | Request to clear the display and home the cursor |
| outValid | output | 1 | Output write valid |
| outReady | input | 1 | Access engine takes the write |
| outByte | output | 8 | Command or data byte |
| outRs | output | 1 | 1 = data write, 0 = command |

## Verification
The main function is driven with a mixed text stream of letters, tabs, carriage returns and newlines, applied at several cursor columns. This separates the four byte classes and shows whether tab and newline lengths depend correctly on the column. A run of 48 characters after a clear follows, then newlines on the last row. These tell the silent line-to-line wrap apart from the commanded wrap at the display's end and from the row wrap of newline. Output stalls, a tab sent into a stalled output, and clearReq raised together with a valid byte tell correct hold and priority apart from lost, doubled or reordered writes.

// File: rtl/txtfmt_pkg.sv
package txtfmt_pkg;

  localparam logic [7:0] CH_TAB      = 8'h09;
  localparam logic [7:0] CH_LF       = 8'h0A;
  localparam logic [7:0] CH_CR       = 8'h0D;
  localparam logic [7:0] CH_SPACE    = 8'h20;
  localparam logic [7:0] CMD_CLEAR   = 8'h01;
  localparam logic [7:0] CMD_SETADDR = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHAR,
    ST_TAB,
    ST_PAD,
    ST_ADDR,
    ST_CLR
  } fmtState_e;

  typedef enum logic [1:0] {
    SRC_HOLD,
    SRC_SPACE,
    SRC_ADDR,
    SRC_CLEAR
  } emitSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     loadByte;     // capture the accepted input byte
    logic     emit;         // load the output register
    emitSrc_e src;          // what the output register takes
    logic     stepCursor;   // auto-increment with line/display wrap
    logic     padStep;      // column +1, never wraps
    logic     homeCol;      // column to first
    logic     homeAll;      // row and column to first
    logic     nextRowHome;  // column to first, row +1 with wrap
    logic     tabLoad;      // load the tab expansion counter
    logic     tabDec;       // one tab space issued
  } fmtStrobe_t;

endpackage

// File: rtl/txtfmt_datapath.sv
module txtfmt_datapath
  import txtfmt_pkg::*;
#(
  parameter int ROWS    = 3,
  parameter int COLS    = 16,
  parameter int TAB_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  fmtStrobe_t stb,
  input  logic [7:0] inByte,
  input  logic       outReady,
  output logic       outValid,
  output logic [7:0] outByte,
  output logic       outRs,
  output logic       isTab,
  output logic       isCr,
  output logic       isLf,
  output logic       atLastCol,
  output logic       atLastRow,
  output logic       tabLast,
  output logic       slotFree
);

  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int TAB_W = $clog2(TAB_LEN + 1);

  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] rowWrap;
  logic [TAB_W-1:0] tabCnt;
  logic [7:0]       holdByte;
  logic [7:0]       cellAddr;
  logic [7:0]       emitByte;

  // input classification
  assign isTab = (inByte == CH_TAB);
  assign isCr  = (inByte == CH_CR);
  assign isLf  = (inByte == CH_LF);

  // cursor (zero based internally)
  assign atLastCol = (col == COL_W'(COLS - 1));
  assign atLastRow = (row == ROW_W'(ROWS - 1));
  assign rowWrap   = atLastRow ? '0 : row + ROW_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      row <= '0;
      col <= '0;
    end else if (stb.homeAll) begin
      row <= '0;
      col <= '0;
    end else if (stb.homeCol) begin
      col <= '0;
    end else if (stb.nextRowHome) begin
      col <= '0;
      row <= rowWrap;
    end else if (stb.stepCursor) begin
      if (atLastCol) begin
        col <= '0;
        row <= rowWrap;
      end else begin
        col <= col + COL_W'(1);
      end
    end else if (stb.padStep) begin
      col <= col + COL_W'(1);
    end
  end

  // cell address: shift-concatenate for power-of-two widths, multiply otherwise
  generate
    if ((COLS & (COLS - 1)) == 0) begin : g_addrPow2
      assign cellAddr = 8'({row, col});
    end else begin : g_addrMul
      assign cellAddr = 8'(row) * 8'(COLS) + 8'(col);
    end
  endgenerate

  // tab expansion counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tabCnt <= '0;
    end else if (stb.tabLoad) begin
      tabCnt <= TAB_W'(TAB_LEN);
    end else if (stb.tabDec) begin
      tabCnt <= tabCnt - TAB_W'(1);
    end
  end
  assign tabLast = (tabCnt == TAB_W'(1));

  // accepted glyph
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdByte <= '0;
    end else if (stb.loadByte) begin
      holdByte <= inByte;
    end
  end

  // output register with valid/ready
  always_comb begin
    unique case (stb.src)
      SRC_HOLD:  emitByte = holdByte;
      SRC_SPACE: emitByte = CH_SPACE;
      SRC_ADDR:  emitByte = CMD_SETADDR | cellAddr;
      default:   emitByte = CMD_CLEAR;
    endcase
  end

  assign slotFree = !outValid || outReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outByte  <= '0;
      outRs    <= 1'b0;
    end else if (stb.emit) begin
      outValid <= 1'b1;
      outByte  <= emitByte;
      outRs    <= (stb.src == SRC_HOLD) || (stb.src == SRC_SPACE);
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/txtfmt_control.sv
module txtfmt_control
  import txtfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       clearReq,
  input  logic       isTab,
  input  logic       isCr,
  input  logic       isLf,
  input  logic       atLastCol,
  input  logic       atLastRow,
  input  logic       tabLast,
  input  logic       slotFree,
  output logic       inReady,
  output fmtStrobe_t stb
);

  fmtState_e state, stateNxt;
  logic      retTab, retTabNxt;
  logic      endOfDisplay;

  assign endOfDisplay = atLastCol && atLastRow;
  assign inReady      = (state == ST_IDLE) && !clearReq;

  always_comb begin
    stb       = '0;
    stb.src   = SRC_HOLD;
    stateNxt  = state;
    retTabNxt = retTab;
    unique case (state)
      ST_IDLE: begin
        if (clearReq) begin
          stb.homeAll = 1'b1;
          stateNxt    = ST_CLR;
        end else if (inValid) begin
          if (isTab) begin
            stb.tabLoad = 1'b1;
            stateNxt    = ST_TAB;
          end else if (isCr) begin
            stb.homeCol = 1'b1;
            retTabNxt   = 1'b0;
            stateNxt    = ST_ADDR;
          end else if (isLf) begin
            stateNxt    = ST_PAD;
          end else begin
            stb.loadByte = 1'b1;
            stateNxt     = ST_CHAR;
          end
        end
      end
      ST_CHAR: begin
        if (slotFree) begin
          stb.emit       = 1'b1;
          stb.src        = SRC_HOLD;
          stb.stepCursor = 1'b1;
          retTabNxt      = 1'b0;
          stateNxt       = endOfDisplay ? ST_ADDR : ST_IDLE;
        end
      end
      ST_TAB: begin
        if (slotFree) begin
          stb.emit       = 1'b1;
          stb.src        = SRC_SPACE;
          stb.stepCursor = 1'b1;
          stb.tabDec     = 1'b1;
          if (endOfDisplay) begin
            retTabNxt = !tabLast;
            stateNxt  = ST_ADDR;
          end else if (tabLast) begin
            stateNxt  = ST_IDLE;
          end
        end
      end
      ST_PAD: begin
        if (slotFree) begin
          stb.emit = 1'b1;
          stb.src  = SRC_SPACE;
          if (atLastCol) begin
            stb.nextRowHome = 1'b1;
            retTabNxt       = 1'b0;
            stateNxt        = ST_ADDR;
          end else begin
            stb.padStep = 1'b1;
          end
        end
      end
      ST_ADDR: begin
        if (slotFree) begin
          stb.emit = 1'b1;
          stb.src  = SRC_ADDR;
          stateNxt = retTab ? ST_TAB : ST_IDLE;
        end
      end
      ST_CLR: begin
        if (slotFree) begin
          stb.emit = 1'b1;
          stb.src  = SRC_CLEAR;
          stateNxt = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      retTab <= 1'b0;
    end else begin
      state  <= stateNxt;
      retTab <= retTabNxt;
    end
  end

endmodule

// File: rtl/txt_cursor_fmt.sv
module txt_cursor_fmt
  import txtfmt_pkg::*;
#(
  parameter int ROWS    = 3,
  parameter int COLS    = 16,
  parameter int TAB_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  input  logic [7:0] inByte,
  input  logic       clearReq,
  output logic       outValid,
  input  logic       outReady,
  output logic [7:0] outByte,
  output logic       outRs
);

  fmtStrobe_t stb;
  logic isTab, isCr, isLf, atLastCol, atLastRow, tabLast, slotFree;

  txtfmt_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .clearReq  (clearReq),
    .isTab     (isTab),
    .isCr      (isCr),
    .isLf      (isLf),
    .atLastCol (atLastCol),
    .atLastRow (atLastRow),
    .tabLast   (tabLast),
    .slotFree  (slotFree),
    .inReady   (inReady),
    .stb       (stb)
  );

  txtfmt_datapath #(
    .ROWS    (ROWS),
    .COLS    (COLS),
    .TAB_LEN (TAB_LEN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .inByte    (inByte),
    .outReady  (outReady),
    .outValid  (outValid),
    .outByte   (outByte),
    .outRs     (outRs),
    .isTab     (isTab),
    .isCr      (isCr),
    .isLf      (isLf),
    .atLastCol (atLastCol),
    .atLastRow (atLastRow),
    .tabLast   (tabLast),
    .slotFree  (slotFree)
  );

endmodule

// File: rtl/txtfmt_checker.sv
module txtfmt_checker #(
  parameter int ROWS = 3,
  parameter int COLS = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic       inReady,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outByte,
  input logic       outRs
);

  // R10: reset keeps the output empty
  p_reset_idle_r10: assert property (@(posedge clk)
    !rstN |=> !outValid);

  // R7: a stalled write holds
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outByte) && $stable(outRs));

  // R8: an accepted byte closes the input for the next cycle
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> !inReady);

  // R5: commands are set-address or clear only
  p_cmd_kind_r5: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outRs |-> (outByte[7] || outByte == 8'h01));

  // R6: set-address stays inside the cell range
  p_addr_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outRs && outByte[7] |-> (outByte[6:0] < 7'(ROWS * COLS)));

endmodule

bind txt_cursor_fmt txtfmt_checker #(
  .ROWS (ROWS),
  .COLS (COLS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outByte  (outByte),
  .outRs    (outRs)
);

// File: tb/tb_txt_cursor_fmt.sv
`timescale 1ns/1ps
module tb_txt_cursor_fmt;

  localparam int ROWS = 3;
  localparam int COLS = 16;
  localparam int TABN = 4;
  localparam int NSTIM = 25;
  localparam logic [7:0] STIM [NSTIM] = '{
    8'h48, 8'h69, 8'h09, 8'h41, 8'h0D, 8'h42, 8'h0A, 8'h43, 8'h44, 8'h09,
    8'h45, 8'h46, 8'h0A, 8'h0A, 8'h31, 8'h32, 8'h0D, 8'h0A, 8'h00, 8'h7F,
    8'h09, 8'h09, 8'h09, 8'h09, 8'h5A
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid, inReady, clearReq, outValid, outReady, outRs;
  logic [7:0] inByte, outByte;

  always #2 clk = ~clk;

  txt_cursor_fmt dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inByte(inByte),
    .clearReq(clearReq), .outValid(outValid), .outReady(outReady),
    .outByte(outByte), .outRs(outRs)
  );

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  int cyc = 0;
  int readyMode = 0;

  logic [7:0] expB[$];
  bit         expR[$];
  string      expT[$];
  logic [7:0] capB[$];
  bit         capR[$];
  int cmpIdx = 0;
  int mRow = 1;
  int mCol = 1;
  bit wrapFlag = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    outReady = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      outReady = (readyMode == 1) ? 1'b0 : ((cyc % 5) != 3);
    end
  end

  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      capB.push_back(outByte);
      capR.push_back(outRs);
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  // reference model built from the requirements
  task automatic pushExp(input logic [7:0] b, input bit rs, input string tag);
    expB.push_back(b);
    expR.push_back(rs);
    expT.push_back(tag);
  endtask

  task automatic putCh(input logic [7:0] b, input string tag);
    string tg;
    tg = wrapFlag ? "R2" : tag;
    wrapFlag = 1'b0;
    pushExp(b, 1'b1, tg);
    if (mCol == COLS) begin
      mCol = 1;
      if (mRow == ROWS) begin
        mRow = 1;
        pushExp(8'h80, 1'b0, "R3");
      end else begin
        mRow++;
        wrapFlag = 1'b1;
      end
    end else begin
      mCol++;
    end
  endtask

  task automatic modelByte(input logic [7:0] b);
    if (b == 8'h09) begin
      for (int k = 0; k < TABN; k++) putCh(8'h20, "R4");
    end else if (b == 8'h0D) begin
      wrapFlag = 1'b0;
      mCol = 1;
      pushExp(8'(8'h80 | ((mRow - 1) * COLS)), 1'b0, "R5");
    end else if (b == 8'h0A) begin
      wrapFlag = 1'b0;
      while (1) begin
        pushExp(8'h20, 1'b1, "R6");
        if (mCol == COLS) break;
        mCol++;
      end
      mCol = 1;
      mRow = (mRow == ROWS) ? 1 : mRow + 1;
      pushExp(8'(8'h80 | ((mRow - 1) * COLS)), 1'b0, "R6");
    end else begin
      putCh(b, "R1");
    end
  endtask

  task automatic modelClear();
    wrapFlag = 1'b0;
    pushExp(8'h01, 1'b0, "R9");
    mRow = 1;
    mCol = 1;
  endtask

  // call at a falling edge
  task automatic sendByte(input logic [7:0] b);
    bit acc;
    modelByte(b);
    inValid = 1'b1;
    inByte  = b;
    do begin
      #1 acc = inReady;
      @(negedge clk);
    end while (!acc);
    inValid = 1'b0;
  endtask

  task automatic waitIdle();
    do begin
      @(negedge clk);
      #1;
    end while (!inReady);
  endtask

  task automatic drainCompare();
    int w;
    w = 0;
    while ((capB.size() < expB.size() || !inReady) && w < 5000) begin
      @(negedge clk);
      #1;
      w++;
    end
    repeat (4) @(negedge clk);
    for (int i = cmpIdx; i < expB.size(); i++) begin
      if (i < capB.size())
        check(capB[i] == expB[i] && capR[i] == expR[i], expT[i], "write {rs,byte}",
              {capR[i], capB[i]}, {expR[i], expB[i]});
      else
        check(1'b0, expT[i], "missing write", 0, {expR[i], expB[i]});
    end
    cmpIdx = expB.size();
    check(capB.size() == expB.size(), "R7", "write count", capB.size(), expB.size());
  endtask

  initial begin
    inValid = 1'b0;
    inByte = 8'h00;
    clearReq = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(outValid == 1'b0, "R10", "outValid in reset", outValid, 0);
    check(inReady == 1'b1, "R10", "inReady in reset", inReady, 1);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: mixed text from the reset cursor (R1, R2, R4, R5, R6, R10)
    for (int i = 0; i < NSTIM; i++) sendByte(STIM[i]);
    drainCompare();

    // clear, then fill the whole display to force the commanded wrap (R9, R2, R3)
    waitIdle();
    modelClear();
    clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
    for (int i = 0; i < ROWS * COLS; i++) sendByte(8'(8'h61 + (i % 26)));
    sendByte(8'h5A);
    // newlines ending on the last row wrap to row 1 (R6)
    sendByte(8'h0A);
    sendByte(8'h0A);
    sendByte(8'h0A);
    sendByte(8'h0D);
    drainCompare();

    // tab at the display end continues after the address command (R3, R4)
    for (int i = 0; i < ROWS * COLS - 2; i++) sendByte(8'h2E);
    sendByte(8'h09);
    drainCompare();

    // stalled expansion keeps the input closed (R8, R7)
    waitIdle();
    readyMode = 1;
    repeat (2) @(negedge clk);
    sendByte(8'h09);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1;
      check(inReady == 1'b0, "R8", "inReady during stalled tab", inReady, 0);
      check(outValid == 1'b1, "R7", "outValid held while stalled", outValid, 1);
    end
    readyMode = 0;
    drainCompare();

    // clearReq beats a simultaneous byte (R9)
    waitIdle();
    modelClear();
    modelByte(8'h51);
    inValid = 1'b1;
    inByte = 8'h51;
    clearReq = 1'b1;
    #1;
    check(inReady == 1'b0, "R9", "inReady with clearReq", inReady, 0);
    @(negedge clk);
    clearReq = 1'b0;
    begin
      bit acc;
      do begin
        #1 acc = inReady;
        @(negedge clk);
      end while (!acc);
    end
    inValid = 1'b0;
    drainCompare();

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule